// File: doc/BRIEF.md
# BCD Time-of-Day and Day-Count Calendar with Alarm

This block keeps wall-clock time for a low-power domain. A free-running slow tick (nominally 32.768 kHz, given as a one-cycle enable on the system clock) feeds a divider. The divider produces one pulse per second. Seconds, minutes and hours are held as packed BCD. Days are a single binary count with no months or years. A second set of registers holds a target minute, hour and day. When the running time reaches that target at the start of a minute, a sticky flag is raised. An enable turns that flag into an interrupt line.

Software reaches all of this through a byte-wide register port with a 4-bit address, a write strobe and a read strobe. Read data is combinational from the address. A read strobe at the seconds address does two things: it returns the live seconds, and it freezes a copy of minutes, hours and days. The following byte reads therefore give one coherent time, even when a rollover happens between them.

Top module: `rtc_calendar`

## Requirements
- R1: After reset every register reads 0x00, counting is stopped and `alarm_irq_o` is low.
- R2: While the run bit (control address 0, bit 0) is 1, seconds advance once per PRESCALE cycles that have `tick_i` high. While it is 0, ticks change neither the time nor the divider.
- R3: Seconds (address 1, bits 6:0) count 0x00 to 0x59 in BCD. A units digit of 9 carries into the tens digit, and 0x59 returns to 0x00 with a carry into minutes.
- R4: Minutes (address 2, bits 6:0) count 0x00 to 0x59 in BCD. 0x59 returns to 0x00 with a carry into hours.
- R5: Hours (address 3, bits 5:0) count 0x00 to 0x23 in BCD. 0x23 returns to 0x00 with a carry into days.
- R6: Days are a DAY_W-bit binary count, with bits 7:0 at address 4 and the upper bits at address 5 (right-aligned). The count wraps from all ones to zero.
- R7: A write to seconds loads the value and clears the sub-second divider, so the next increment comes PRESCALE ticks later. A write to any time field takes precedence over that field's increment in the same cycle, and a written field passes no carry onward.
- R8: A read strobe at address 1 captures minutes, hours and days. Addresses 2 to 5 return that capture, not the live value.
- R9: Alarm minutes (address 6, BCD), alarm hours (address 7, BCD) and alarm day (addresses 8 and 9, binary, split like R6) read back as written.
- R10: The alarm flag (address 0, bit 2) sets on the edge where a seconds increment makes the time mm:hh:day with seconds 00 equal to the alarm. It stays set until a write to address 0 with bit 2 = 1. A new match wins over a clear in the same cycle.
- R11: `alarm_irq_o` is high exactly when the alarm flag and the interrupt enable (address 0, bit 1) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow-oscillator tick enable, one cycle wide |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (address 1 captures the time) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
The hardest cases are the far end of the carry chain: a day wrap from 0x7FFF, a field write that lands in the same cycle as an incoming carry, and an alarm that must fire only on the seconds-00 boundary. The bench loads the fields just below their limits, shrinks the divider to four ticks and runs at full tick rate, so every field crosses its limit within a few dozen cycles.

A behavioural model counts in plain decimal integers. It is checked against every read address in rotation on every clock. Writes, stopped intervals, sparse ticks and a read capture held across a rollover are mixed into the runs.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [3:0] {
      RA_CTRL  = 4'd0,
      RA_SEC   = 4'd1,
      RA_MIN   = 4'd2,
      RA_HOUR  = 4'd3,
      RA_DAYL  = 4'd4,
      RA_DAYH  = 4'd5,
      RA_AMIN  = 4'd6,
      RA_AHOUR = 4'd7,
      RA_ADAYL = 4'd8,
      RA_ADAYH = 4'd9
   } rtc_addr_e;

   localparam int CTRL_RUN  = 0;
   localparam int CTRL_IE   = 1;
   localparam int CTRL_FLAG = 2;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic tick_i,
   input  logic clr_i,
   output logic pulse_o
);
   localparam int  CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  POW2 = (DIV == (1 << CW));

   logic [CW-1:0] cnt_q;
   logic          at_end;

   if (DIV < 2) begin : g_bad_div
      $error("rtc_prescaler: DIV must be at least 2");
   end

   if (POW2) begin : g_pow2
      assign at_end = &cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                cnt_q <= '0;
         else if (clr_i)             cnt_q <= '0;
         else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_cmp
      assign at_end = (cnt_q == CW'(DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                cnt_q <= '0;
         else if (clr_i)             cnt_q <= '0;
         else if (run_i && tick_i)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
      end
   end

   assign pulse_o = run_i & tick_i & at_end & ~clr_i;

   AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0)); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !clr_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
   parameter int TENS_W = 3,
   parameter int MAX_T  = 5,
   parameter int MAX_U  = 9
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              inc_i,
   input  logic              wr_i,
   input  logic [TENS_W+3:0] wr_val_i,
   output logic [TENS_W+3:0] q_o,
   output logic [TENS_W+3:0] nxt_o,
   output logic              carry_o
);
   localparam int W = TENS_W + 4;
   localparam logic [W-1:0] MAXV = {TENS_W'(MAX_T), 4'(MAX_U)};

   if (MAX_U > 9 || MAX_T >= (1 << TENS_W)) begin : g_bad_limit
      $error("rtc_bcd_field: limit does not fit a BCD field");
   end

   always_comb begin
      nxt_o = q_o;
      if (wr_i) begin
         nxt_o = wr_val_i;
      end else if (inc_i) begin
         if (q_o == MAXV)             nxt_o = '0;
         else if (q_o[3:0] >= 4'd9)   nxt_o = {q_o[W-1:4] + 1'b1, 4'd0};
         else                         nxt_o = q_o + 1'b1;
      end
   end

   assign carry_o = inc_i & ~wr_i & (q_o == MAXV);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= nxt_o;
   end

   AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !wr_i && q_o == MAXV) |=> (q_o == '0)); // R3
   AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !wr_i) |=> $stable(q_o)); // R2
   AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (q_o == $past(wr_val_i))); // R7
endmodule

// File: rtl/rtc_day_count.sv
module rtc_day_count #(
   parameter int DAY_W = 15
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               inc_i,
   input  logic               wr_lo_i,
   input  logic               wr_hi_i,
   input  logic [7:0]         wdata_lo_i,
   input  logic [DAY_W-9:0]   wdata_hi_i,
   output logic [DAY_W-1:0]   q_o,
   output logic [DAY_W-1:0]   nxt_o
);
   always_comb begin
      nxt_o = q_o;
      if (wr_lo_i || wr_hi_i) begin
         if (wr_lo_i) nxt_o[7:0]       = wdata_lo_i;
         if (wr_hi_i) nxt_o[DAY_W-1:8] = wdata_hi_i;
      end else if (inc_i) begin
         nxt_o = q_o + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= nxt_o;
   end

   AST_DAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && !wr_lo_i && !wr_hi_i && (&q_o)) |=> (q_o == '0)); // R6
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
   parameter int DAY_W = 15
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_min_i,
   input  logic             wr_hour_i,
   input  logic             wr_dlo_i,
   input  logic             wr_dhi_i,
   input  logic [7:0]       wdata_i,
   input  logic             clr_i,
   input  logic             sec_pulse_i,
   input  logic [6:0]       sec_nxt_i,
   input  logic [6:0]       min_nxt_i,
   input  logic [5:0]       hour_nxt_i,
   input  logic [DAY_W-1:0] day_nxt_i,
   output logic [6:0]       amin_o,
   output logic [5:0]       ahour_o,
   output logic [DAY_W-1:0] aday_o,
   output logic             flag_o
);
   logic match;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         amin_o  <= '0;
         ahour_o <= '0;
         aday_o  <= '0;
      end else begin
         if (wr_min_i)  amin_o  <= wdata_i[6:0];
         if (wr_hour_i) ahour_o <= wdata_i[5:0];
         if (wr_dlo_i)  aday_o[7:0] <= wdata_i;
         if (wr_dhi_i)  aday_o[DAY_W-1:8] <= wdata_i[DAY_W-9:0];
      end
   end

   assign match = sec_pulse_i && (sec_nxt_i == '0) && (min_nxt_i == amin_o)
                  && (hour_nxt_i == ahour_o) && (day_nxt_i == aday_o);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     flag_o <= 1'b0;
      else if (match)  flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !clr_i) |=> flag_o); // R10
   AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> $past(sec_pulse_i)); // R10
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import rtc_pkg::*;
#(
   parameter int PRESCALE = 32768,
   parameter int DAY_W    = 15
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tick_i,
   input  logic       reg_wr_i,
   input  logic       reg_rd_i,
   input  logic [3:0] reg_addr_i,
   input  logic [7:0] reg_wdata_i,
   output logic [7:0] reg_rdata_o,
   output logic       alarm_irq_o
);
   localparam int HI_W = DAY_W - 8;

   if (DAY_W < 9 || DAY_W > 16) begin : g_bad_day_w
      $error("rtc_calendar: DAY_W must lie between 9 and 16");
   end

   logic run_q, ie_q, flag;
   logic wr_ctrl, wr_sec, wr_min, wr_hour, wr_dlo, wr_dhi;
   logic wr_amin, wr_ahour, wr_adlo, wr_adhi, snap_en, flag_clr;
   logic sec_pulse, sec_carry, min_carry, hour_carry;
   logic [6:0] sec_q, sec_nxt, min_q, min_nxt, amin;
   logic [5:0] hour_q, hour_nxt, ahour;
   logic [DAY_W-1:0] day_q, day_nxt, aday;
   logic [6:0] snap_min;
   logic [5:0] snap_hour;
   logic [DAY_W-1:0] snap_day;

   assign wr_ctrl  = reg_wr_i && (reg_addr_i == RA_CTRL);
   assign wr_sec   = reg_wr_i && (reg_addr_i == RA_SEC);
   assign wr_min   = reg_wr_i && (reg_addr_i == RA_MIN);
   assign wr_hour  = reg_wr_i && (reg_addr_i == RA_HOUR);
   assign wr_dlo   = reg_wr_i && (reg_addr_i == RA_DAYL);
   assign wr_dhi   = reg_wr_i && (reg_addr_i == RA_DAYH);
   assign wr_amin  = reg_wr_i && (reg_addr_i == RA_AMIN);
   assign wr_ahour = reg_wr_i && (reg_addr_i == RA_AHOUR);
   assign wr_adlo  = reg_wr_i && (reg_addr_i == RA_ADAYL);
   assign wr_adhi  = reg_wr_i && (reg_addr_i == RA_ADAYH);
   assign snap_en  = reg_rd_i && (reg_addr_i == RA_SEC);
   assign flag_clr = wr_ctrl && reg_wdata_i[CTRL_FLAG];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         ie_q  <= 1'b0;
      end else if (wr_ctrl) begin
         run_q <= reg_wdata_i[CTRL_RUN];
         ie_q  <= reg_wdata_i[CTRL_IE];
      end
   end

   rtc_prescaler #(.DIV(PRESCALE)) u_pre (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .tick_i(tick_i),
      .clr_i(wr_sec), .pulse_o(sec_pulse));

   rtc_bcd_field #(.TENS_W(3), .MAX_T(5), .MAX_U(9)) u_sec (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_pulse), .wr_i(wr_sec),
      .wr_val_i(reg_wdata_i[6:0]), .q_o(sec_q), .nxt_o(sec_nxt), .carry_o(sec_carry));

   rtc_bcd_field #(.TENS_W(3), .MAX_T(5), .MAX_U(9)) u_min (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(sec_carry), .wr_i(wr_min),
      .wr_val_i(reg_wdata_i[6:0]), .q_o(min_q), .nxt_o(min_nxt), .carry_o(min_carry));

   rtc_bcd_field #(.TENS_W(2), .MAX_T(2), .MAX_U(3)) u_hour (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(min_carry), .wr_i(wr_hour),
      .wr_val_i(reg_wdata_i[5:0]), .q_o(hour_q), .nxt_o(hour_nxt), .carry_o(hour_carry));

   rtc_day_count #(.DAY_W(DAY_W)) u_day (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(hour_carry), .wr_lo_i(wr_dlo),
      .wr_hi_i(wr_dhi), .wdata_lo_i(reg_wdata_i), .wdata_hi_i(reg_wdata_i[HI_W-1:0]),
      .q_o(day_q), .nxt_o(day_nxt));

   rtc_alarm_unit #(.DAY_W(DAY_W)) u_alarm (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_min_i(wr_amin), .wr_hour_i(wr_ahour),
      .wr_dlo_i(wr_adlo), .wr_dhi_i(wr_adhi), .wdata_i(reg_wdata_i), .clr_i(flag_clr),
      .sec_pulse_i(sec_pulse), .sec_nxt_i(sec_nxt), .min_nxt_i(min_nxt),
      .hour_nxt_i(hour_nxt), .day_nxt_i(day_nxt), .amin_o(amin), .ahour_o(ahour),
      .aday_o(aday), .flag_o(flag));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         snap_min  <= '0;
         snap_hour <= '0;
         snap_day  <= '0;
      end else if (snap_en) begin
         snap_min  <= min_q;
         snap_hour <= hour_q;
         snap_day  <= day_q;
      end
   end

   always_comb begin
      case (reg_addr_i)
         RA_CTRL:  reg_rdata_o = {5'b0, flag, ie_q, run_q};
         RA_SEC:   reg_rdata_o = {1'b0, sec_q};
         RA_MIN:   reg_rdata_o = {1'b0, snap_min};
         RA_HOUR:  reg_rdata_o = {2'b0, snap_hour};
         RA_DAYL:  reg_rdata_o = snap_day[7:0];
         RA_DAYH:  reg_rdata_o = 8'(snap_day[DAY_W-1:8]);
         RA_AMIN:  reg_rdata_o = {1'b0, amin};
         RA_AHOUR: reg_rdata_o = {2'b0, ahour};
         RA_ADAYL: reg_rdata_o = aday[7:0];
         RA_ADAYH: reg_rdata_o = 8'(aday[DAY_W-1:8]);
         default:  reg_rdata_o = 8'h00;
      endcase
   end

   assign alarm_irq_o = flag & ie_q;

   AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !wr_sec) |=> $stable(sec_q)); // R2
   AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !snap_en |=> $stable(snap_day)); // R8
   AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_irq_o |-> ie_q); // R11
endmodule

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
   localparam int P = 4;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [3:0] addr = 4'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;

   always #10 clk = ~clk;

   rtc_calendar #(.PRESCALE(P), .DAY_W(15)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_wr_i(wr), .reg_rd_i(rd),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .alarm_irq_o(irq));

   int    checks = 0, errors = 0;
   string tag = "R1";
   bit    done = 0;

   // behavioural model, plain decimal integers
   int m_sec, m_min, m_hour, m_day, m_pre, m_amin, m_ahour, m_aday;
   int s_min, s_hour, s_day;
   bit m_run, m_ie, m_flag;
   int ns, nm, nh, nd;
   bit pulse, rs, rm, rh, match;

   function automatic int bcd(int v); return (v / 10) * 16 + v % 10; endfunction
   function automatic int dec(int b); return (b / 16) * 10 + b % 16; endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = 0; m_min = 0; m_hour = 0; m_day = 0; m_pre = 0;
         m_amin = 0; m_ahour = 0; m_aday = 0; s_min = 0; s_hour = 0; s_day = 0;
         m_run = 0; m_ie = 0; m_flag = 0;
      end else begin
         pulse = 0;
         if (wr && addr == 1) m_pre = 0;
         else if (m_run && tick) begin
            if (m_pre == P - 1) begin m_pre = 0; pulse = 1; end
            else m_pre = m_pre + 1;
         end
         rs = pulse && m_sec == 59;
         ns = (wr && addr == 1) ? dec(int'(wdata)) : (pulse ? (rs ? 0 : m_sec + 1) : m_sec);
         rm = rs && m_min == 59 && !(wr && addr == 2);
         nm = (wr && addr == 2) ? dec(int'(wdata)) : (rs ? (m_min == 59 ? 0 : m_min + 1) : m_min);
         rh = rm && m_hour == 23 && !(wr && addr == 3);
         nh = (wr && addr == 3) ? dec(int'(wdata)) : (rm ? (m_hour == 23 ? 0 : m_hour + 1) : m_hour);
         nd = m_day;
         if (wr && addr == 4)      nd = (m_day & 'h7F00) | int'(wdata);
         else if (wr && addr == 5) nd = (m_day & 'hFF) | ((int'(wdata) & 'h7F) << 8);
         else if (rh)              nd = (m_day + 1) % 32768;
         match = pulse && ns == 0 && nm == m_amin && nh == m_ahour && nd == m_aday;
         if (rd && addr == 1) begin s_min = m_min; s_hour = m_hour; s_day = m_day; end
         if (match) m_flag = 1;
         else if (wr && addr == 0 && wdata[2]) m_flag = 0;
         if (wr && addr == 0) begin m_run = wdata[0]; m_ie = wdata[1]; end
         if (wr && addr == 6) m_amin = dec(int'(wdata));
         if (wr && addr == 7) m_ahour = dec(int'(wdata));
         if (wr && addr == 8) m_aday = (m_aday & 'h7F00) | int'(wdata);
         if (wr && addr == 9) m_aday = (m_aday & 'hFF) | ((int'(wdata) & 'h7F) << 8);
         m_sec = ns; m_min = nm; m_hour = nh; m_day = nd;
      end
   end

   function automatic logic [7:0] exp_rd(logic [3:0] a);
      case (a)
         4'd0: return {5'b0, m_flag, m_ie, m_run};
         4'd1: return 8'(bcd(m_sec));
         4'd2: return 8'(bcd(s_min));
         4'd3: return 8'(bcd(s_hour));
         4'd4: return 8'(s_day & 255);
         4'd5: return 8'(s_day >> 8);
         4'd6: return 8'(bcd(m_amin));
         4'd7: return 8'(bcd(m_ahour));
         4'd8: return 8'(m_aday & 255);
         4'd9: return 8'(m_aday >> 8);
         default: return 8'h00;
      endcase
   endfunction

   task automatic compare();
      logic [7:0] e;
      e = exp_rd(addr);
      checks++;
      if (rdata !== e) begin
         errors++;
         $display("FAIL %s: addr %0d rdata=%h expected=%h", tag, addr, rdata, e);
      end
      checks++;
      if (irq !== (m_flag & m_ie)) begin
         errors++;
         $display("FAIL %s R11: irq=%b expected=%b", tag, irq, m_flag & m_ie);
      end
   endtask

   task automatic cyc(bit w, bit r, logic [3:0] a, logic [7:0] d, bit t);
      @(negedge clk);
      compare();
      wr = w; rd = r; addr = a; wdata = d; tick = t;
   endtask

   task automatic wreg(logic [3:0] a, logic [7:0] d);
      cyc(1'b1, 1'b0, a, d, 1'b0);
   endtask

   // tmode: 0 no tick, 1 every cycle, 2 every other cycle
   task automatic idle(int n, int tmode);
      for (int i = 0; i < n; i++) begin
         logic [3:0] a;
         bit t;
         a = 4'(i % 10);
         t = (tmode == 1) ? 1'b1 : ((tmode == 2) ? i[0] : 1'b0);
         cyc(1'b0, a == 4'd1, a, 8'h00, t);
      end
   endtask

   initial begin
      tag = "R1 reset";
      idle(4, 0);
      rst_n = 1'b1;
      idle(12, 0);

      tag = "R9 alarm readback";
      wreg(6, 8'h45); wreg(7, 8'h12); wreg(8, 8'h23); wreg(9, 8'h01);
      idle(12, 0);

      tag = "R3 R4 R5 R6 rollover and day wrap";
      wreg(2, 8'h59); wreg(3, 8'h23); wreg(4, 8'hFF); wreg(5, 8'h7F);
      wreg(1, 8'h57); wreg(0, 8'h01);
      idle(60, 1);

      tag = "R2 stopped and sparse ticks";
      wreg(0, 8'h00);
      idle(30, 1);
      wreg(0, 8'h01);
      idle(40, 2);

      tag = "R7 seconds write clears divider";
      idle(5, 1);
      cyc(1'b1, 1'b0, 4'd1, 8'h09, 1'b1);
      idle(3, 1);
      cyc(1'b1, 1'b0, 4'd1, 8'h59, 1'b1);
      idle(3, 1);
      cyc(1'b1, 1'b0, 4'd2, 8'h30, 1'b1);
      idle(20, 1);

      tag = "R3 R4 long run";
      idle(260, 1);

      tag = "R8 capture held across rollover";
      wreg(1, 8'h58);
      cyc(1'b0, 1'b1, 4'd1, 8'h00, 1'b1);
      for (int i = 0; i < 40; i++) cyc(1'b0, 1'b0, 4'(2 + i % 4), 8'h00, 1'b1);
      idle(10, 1);

      tag = "R10 alarm match and sticky flag";
      wreg(0, 8'h01);
      wreg(4, 8'h05); wreg(5, 8'h00); wreg(3, 8'h07); wreg(2, 8'h14); wreg(1, 8'h58);
      wreg(6, 8'h15); wreg(7, 8'h07); wreg(8, 8'h05); wreg(9, 8'h00);
      idle(20, 1);
      tag = "R11 irq gated by enable";
      wreg(0, 8'h03);
      idle(12, 1);
      tag = "R10 write-one clear";
      wreg(0, 8'h03);
      idle(4, 1);
      wreg(0, 8'h07);
      idle(12, 1);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: run still active, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule